// File: doc/BRIEF.md
# Truncated-Modulus Loadable Counter

This block is a synchronous up-counter of parameterized width with two independent
count-enable inputs, a parallel load path, a synchronous clear and a carry-out that
lets a following stage be chained from it. All state changes happen on the rising
clock edge.

A decode of the last valid state shortens the count sequence to a parameterized
modulus. With the default settings (4 bits, modulus 12) the counter steps 0, 1, … 11
and then returns to 0. The invalid state 12 is never reached by counting.

A one-cycle wrap pulse marks each return to zero that comes from counting. The clear
and the load inputs are plain control pins. The count and the carry are plain status
outputs. There is no stream interface, so no back-pressure rules apply.

Top module: `mod_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 and `wrap` becomes 0.
- R2: When `clr` is high at a rising edge, the count becomes 0 on that edge. This holds whatever `load`, `en_p` and `en_t` are doing.
- R3: When `load` is high and `clr` is low at a rising edge, the count takes the value of `din` on that edge. Load wins over counting.
- R4: When `en_p` and `en_t` are both high, and neither `clr` nor `load` is high, each rising edge adds one to the count.
- R5: When either `en_p` or `en_t` is low, and neither `clr` nor `load` is high, the count keeps its value across the edge.
- R6: When the count equals MODULUS-1 (11 by default) and it advances under R4, the next value is 0. Counting never produces the value MODULUS.
- R7: `wrap` is high for exactly the one cycle after an edge that took the count from MODULUS-1 to 0 by counting. It is low after a clear, after a load, and after a roll from all-ones to 0.
- R8: `rco` is high exactly when the count is all-ones (15 by default) and `en_t` is high. It follows `en_t` without waiting for a clock edge.
- R9: A loaded value at or above MODULUS keeps counting upward by one. From all-ones it rolls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load strobe |
| din | input | WIDTH | Value copied in on load |
| en_p | input | 1 | Count enable, not gating the carry |
| en_t | input | 1 | Count enable that also gates `rco` |
| count | output | WIDTH | Current count |
| rco | output | 1 | Carry-out for chaining |
| wrap | output | 1 | One-cycle pulse after a modulus wrap |

## Verification
The assertions assume the following:
- Every input carries a defined 0 or 1 after reset is released.
- MODULUS is between 2 and 2**WIDTH.

The stimulus keeps within these limits. It drives every input to a known value from time zero. It changes inputs only at the falling clock edge, so nothing moves near a sampling edge. It keeps the default parameters.

The scenarios reach the last valid state through plain counting. They also place the count above the modulus through a load, to exercise the roll from all-ones.

// File: rtl/mod_counter_pkg.sv
package mod_counter_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import mod_counter_pkg::*;
(
  input  logic clr,
  input  logic load,
  input  logic cnt_en,
  output act_e act
);
  // Fixed priority: clear, load, count, hold.
  always_comb begin
    if (clr)         act = ACT_CLEAR;
    else if (load)   act = ACT_LOAD;
    else if (cnt_en) act = ACT_COUNT;
    else             act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 12
) (
  input  logic [WIDTH-1:0] count,
  input  logic             cnt_en,
  input  logic             en_t,
  output logic             at_last,
  output logic             rco
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};

  generate
    if (MODULUS < (1 << WIDTH)) begin : g_trunc
      assign at_last = cnt_en && (count == LAST);
    end else begin : g_full
      assign at_last = cnt_en && (count == TOP);
    end
  endgenerate

  assign rco = en_t && (count == TOP);
endmodule

// File: rtl/cnt_core.sv
module cnt_core
  import mod_counter_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic             at_last,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] nxt;
  logic             wrap_d;

  always_comb begin
    wrap_d = 1'b0;
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = din;
      ACT_COUNT: begin
        if (at_last) begin
          nxt    = '0;
          wrap_d = 1'b1;
        end else begin
          nxt = count + 1'b1;
        end
      end
      default:   nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      count <= nxt;
      wrap  <= wrap_d;
    end
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_CLEAR |=> count == '0);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_LOAD |=> count == $past(din));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_HOLD |=> $stable(count));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_COUNT && count != LAST) |=> count == WIDTH'($past(count) + 1'b1));
  assert_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_COUNT && count == LAST) |=> (count == '0 && wrap));
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> count == '0);
  assert_wrap_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);
endmodule

// File: rtl/mod_counter.sv
module mod_counter
  import mod_counter_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] count,
  output logic             rco,
  output logic             wrap
);
  logic cnt_en;
  logic at_last;
  act_e act;

  assign cnt_en = en_p && en_t;

  cnt_ctrl u_ctrl (
    .clr    (clr),
    .load   (load),
    .cnt_en (cnt_en),
    .act    (act)
  );

  cnt_term #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_term (
    .count   (count),
    .cnt_en  (cnt_en),
    .en_t    (en_t),
    .at_last (at_last),
    .rco     (rco)
  );

  cnt_core #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .at_last (at_last),
    .din     (din),
    .count   (count),
    .wrap    (wrap)
  );

  assert_rco_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rco |-> (en_t && count == {WIDTH{1'b1}}));
endmodule

// File: tb/sim_mod_counter.sv
module sim_mod_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load = 1'b0;
  logic [3:0] din = 4'd0;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic [3:0] count;
  logic       rco;
  logic       wrap;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mod_counter u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .din(din),
    .en_p(en_p), .en_t(en_t), .count(count), .rco(rco), .wrap(wrap)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    step();
    chk("R1 count", count, 0);
    chk("R1 wrap", wrap, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_count_run();
    en_p = 1'b1;
    en_t = 1'b1;
    for (int i = 1; i <= 11; i++) begin
      step();
      chk("R4 count", count, i);
      chk("R7 no wrap", wrap, 0);
    end
    step();
    chk("R6 back to 0", count, 0);
    chk("R7 wrap", wrap, 1);
    step();
    chk("R4 after wrap", count, 1);
    chk("R7 wrap one cycle", wrap, 0);
  endtask

  task automatic t_hold();
    en_p = 1'b0;
    en_t = 1'b1;
    step();
    chk("R5 en_p low", count, 1);
    en_p = 1'b1;
    en_t = 1'b0;
    step();
    chk("R5 en_t low", count, 1);
    en_t = 1'b1;
  endtask

  task automatic t_load();
    load = 1'b1;
    din = 4'd7;
    step();
    load = 1'b0;
    chk("R3 load over count", count, 7);
  endtask

  task automatic t_clear();
    clr = 1'b1;
    load = 1'b1;
    din = 4'd5;
    step();
    chk("R2 clear over load", count, 0);
    clr = 1'b0;
    din = 4'd11;
    step();
    load = 1'b0;
    chk("R3 load 11", count, 11);
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R2 clear at last", count, 0);
    chk("R7 no wrap on clear", wrap, 0);
  endtask

  task automatic t_high();
    load = 1'b1;
    din = 4'd13;
    step();
    load = 1'b0;
    chk("R9 load 13", count, 13);
    step();
    chk("R9 14", count, 14);
    step();
    chk("R9 15", count, 15);
    chk("R8 rco high", rco, 1);
    step();
    chk("R9 roll to 0", count, 0);
    chk("R7 no wrap on roll", wrap, 0);
    chk("R8 rco low", rco, 0);
  endtask

  task automatic t_rco_gate();
    en_p = 1'b0;
    en_t = 1'b0;
    load = 1'b1;
    din = 4'd15;
    step();
    load = 1'b0;
    chk("R3 load 15", count, 15);
    chk("R8 rco gated", rco, 0);
    en_t = 1'b1;
    #1;
    chk("R8 rco follows en_t", rco, 1);
    step();
    chk("R5 hold at 15", count, 15);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count_run();
    t_hold();
    t_load();
    t_clear();
    t_high();
    t_rco_gate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule